// File: doc/BRIEF.md
# Block Cipher Engine Status and Interrupt Unit

This unit holds the control, status and interrupt logic of a block-cipher accelerator. It does not contain the cipher rounds. A cycle-accurate busy timer takes their place and models how long one 128-bit block takes. The duration depends on the selected operation and on whether a short (128-bit) or long (256-bit) key is in use.

Three sticky event flags are kept:
- block done;
- illegal data read;
- illegal data write.

The done flag has its own interrupt enable and its own write-one clear strobe. The two error flags share one enable and one clear. All enabled sources merge into a single interrupt line. An illegal access does not stop the block in progress: the timer runs to the end and the done flag is still raised.

A start pulse samples the operation and the key length and launches the timer. The enable levels and clear strobes come from a register file outside this unit. The violation pulses come from the data-port logic.

Top module: `cryptoStatusTop`

## Requirements
- R1: After reset, `busy`, `doneFlag`, `rdErrFlag`, `wrErrFlag` and `irqOut` are all 0.
- R2: With `keyLong`=0, an accepted start holds `busy` high for exactly 51 cycles for operation code 2'b00 (encrypt), 59 cycles for 2'b01 (key derivation), and 51 cycles for 2'b10 or 2'b11 (decrypt).
- R3: With `keyLong`=1, the same codes give 75, 82 and 75 busy cycles.
- R4: `doneFlag` rises on the same clock edge that `busy` falls, and stays set until a `doneClr` strobe.
- R5: A start pulse while `busy` is high is ignored. Operation and key length are captured only when a start is accepted, so later changes to those inputs do not alter the running block's duration.
- R6: A `rdViolation` or `wrViolation` pulse while `busy` is high sets `rdErrFlag` or `wrErrFlag` on the next edge. Pulses while idle have no effect.
- R7: A write violation during a block neither shortens nor ends it. `busy` keeps its full length and `doneFlag` is still set at the end.
- R8: `errClr` clears both error flags and leaves `doneFlag` alone. `doneClr` clears only `doneFlag`.
- R9: When a clear strobe and a set event for the same flag land in the same cycle, the flag ends up set.
- R10: `irqOut` = (`doneFlag` & `doneIrqEn`) | ((`rdErrFlag` | `wrErrFlag`) & `errIrqEn`). The enables never change the flag values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Launch one block when idle |
| opSel | input | 2 | Operation: 00 encrypt, 01 key derivation, 10/11 decrypt |
| keyLong | input | 1 | 1 = 256-bit key, 0 = 128-bit key |
| doneIrqEn | input | 1 | Interrupt enable for the done flag |
| errIrqEn | input | 1 | Shared interrupt enable for both error flags |
| doneClr | input | 1 | Write-one clear of the done flag |
| errClr | input | 1 | Write-one clear of both error flags |
| rdViolation | input | 1 | Data read attempted (illegal when busy) |
| wrViolation | input | 1 | Data write attempted (illegal when busy) |
| busy | output | 1 | Block in progress |
| doneFlag | output | 1 | Block-complete flag |
| rdErrFlag | output | 1 | Read error flag |
| wrErrFlag | output | 1 | Write error flag |
| irqOut | output | 1 | Combined interrupt |

## Verification
Directed runs cover the following patterns:
- All six operation and key-length pairs are timed. This separates the key-derivation counts from the encrypt and decrypt counts, and the short-key counts from the long-key counts.
- A second start, and changes to the operation inputs, are injected mid-block. These show whether a block relaunches or re-reads its settings.
- Clear strobes are placed in the exact cycle of a set event, to tell set-priority from clear-priority.
- A write error placed near the end of a block tells an abort apart from the required continuation.

Seeded random runs then mix operations, enable levels, clears and violations. Each run is checked against flag and interrupt values modelled in the bench.

// File: rtl/cryptoStatPkg.sv
package cryptoStatPkg;

  typedef enum logic [1:0] {
    OP_ENCRYPT = 2'b00,
    OP_KEYDER  = 2'b01,
    OP_DECRYPT = 2'b10,
    OP_DECALT  = 2'b11
  } opCode_t;

  typedef struct packed {
    logic doneEvt;
    logic rdErrEvt;
    logic wrErrEvt;
  } evtStrobes_t;

  localparam int NUM_FLAGS = 3;

  function automatic int maxOf6(input int a, input int b, input int c,
                                input int d, input int e, input int f);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return m;
  endfunction

endpackage

// File: rtl/cryptoBusyTimer.sv
module cryptoBusyTimer
  import cryptoStatPkg::*;
#(
  parameter int LAT_ENC_S = 51,
  parameter int LAT_KDR_S = 59,
  parameter int LAT_DEC_S = 51,
  parameter int LAT_ENC_L = 75,
  parameter int LAT_KDR_L = 82,
  parameter int LAT_DEC_L = 75
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [1:0]  opSel,
  input  logic        keyLong,
  input  logic        rdViolation,
  input  logic        wrViolation,
  output logic        busy,
  output evtStrobes_t evt
);

  localparam int MAX_LAT = maxOf6(LAT_ENC_S, LAT_KDR_S, LAT_DEC_S,
                                  LAT_ENC_L, LAT_KDR_L, LAT_DEC_L);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  opCode_t          opQ;
  logic             keyQ;
  logic [CNT_W-1:0] latSel;
  logic             lastCycle;
  logic             startOk;

  always_comb begin
    latSel = '0;
    unique case (opQ)
      OP_ENCRYPT: latSel = keyQ ? CNT_W'(LAT_ENC_L) : CNT_W'(LAT_ENC_S);
      OP_KEYDER:  latSel = keyQ ? CNT_W'(LAT_KDR_L) : CNT_W'(LAT_KDR_S);
      OP_DECRYPT,
      OP_DECALT:  latSel = keyQ ? CNT_W'(LAT_DEC_L) : CNT_W'(LAT_DEC_S);
      default:    latSel = '0;
    endcase
  end

  assign lastCycle = busyQ && (cntQ == latSel);
  assign startOk   = startPulse && !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
      opQ   <= OP_ENCRYPT;
      keyQ  <= 1'b0;
    end else if (startOk) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_W'(1);
      opQ   <= opCode_t'(opSel);
      keyQ  <= keyLong;
    end else if (lastCycle) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (busyQ) begin
      cntQ  <= cntQ + CNT_W'(1);
    end
  end

  assign busy         = busyQ;
  assign evt.doneEvt  = lastCycle;
  assign evt.rdErrEvt = busyQ && rdViolation;
  assign evt.wrErrEvt = busyQ && wrViolation;

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cntQ >= CNT_W'(1)) && (cntQ <= latSel)); // R2
  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastCycle) |=> busyQ && (cntQ == $past(cntQ) + CNT_W'(1))); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startPulse) |=> $stable(opQ) && $stable(keyQ)); // R5
  AST_WR_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && wrViolation && !lastCycle) |=> busyQ); // R7

endmodule

// File: rtl/cryptoFlagBank.sv
module cryptoFlagBank
  import cryptoStatPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  evtStrobes_t evt,
  input  logic        doneIrqEn,
  input  logic        errIrqEn,
  input  logic        doneClr,
  input  logic        errClr,
  output logic        doneFlag,
  output logic        rdErrFlag,
  output logic        wrErrFlag,
  output logic        irqOut
);

  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] clrVec;
  logic [NUM_FLAGS-1:0] flagQ;

  // bit 2 done, bit 1 read error, bit 0 write error
  assign setVec = {evt.doneEvt, evt.rdErrEvt, evt.wrErrEvt};
  assign clrVec = {doneClr, errClr, errClr};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flagQ[g] <= 1'b0;
      else if (setVec[g]) flagQ[g] <= 1'b1;
      else if (clrVec[g]) flagQ[g] <= 1'b0;
    end
  end

  assign doneFlag  = flagQ[2];
  assign rdErrFlag = flagQ[1];
  assign wrErrFlag = flagQ[0];
  assign irqOut    = (doneFlag & doneIrqEn) | ((rdErrFlag | wrErrFlag) & errIrqEn);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evt.doneEvt |=> doneFlag); // R9
  AST_ERR_CLR_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !evt.rdErrEvt && !evt.wrErrEvt) |=> !rdErrFlag && !wrErrFlag); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!evt.doneEvt && !doneClr) |=> $stable(doneFlag)); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!doneIrqEn && !errIrqEn) |-> !irqOut); // R10
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rdErrEvt || evt.wrErrEvt) |=> (rdErrFlag || wrErrFlag)); // R6

endmodule

// File: rtl/cryptoStatusTop.sv
module cryptoStatusTop
  import cryptoStatPkg::*;
#(
  parameter int LAT_ENC_S = 51,
  parameter int LAT_KDR_S = 59,
  parameter int LAT_DEC_S = 51,
  parameter int LAT_ENC_L = 75,
  parameter int LAT_KDR_L = 82,
  parameter int LAT_DEC_L = 75
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [1:0] opSel,
  input  logic       keyLong,
  input  logic       doneIrqEn,
  input  logic       errIrqEn,
  input  logic       doneClr,
  input  logic       errClr,
  input  logic       rdViolation,
  input  logic       wrViolation,
  output logic       busy,
  output logic       doneFlag,
  output logic       rdErrFlag,
  output logic       wrErrFlag,
  output logic       irqOut
);

  evtStrobes_t evtBus;

  cryptoBusyTimer #(
    .LAT_ENC_S(LAT_ENC_S), .LAT_KDR_S(LAT_KDR_S), .LAT_DEC_S(LAT_DEC_S),
    .LAT_ENC_L(LAT_ENC_L), .LAT_KDR_L(LAT_KDR_L), .LAT_DEC_L(LAT_DEC_L)
  ) timer_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opSel(opSel),
    .keyLong(keyLong), .rdViolation(rdViolation), .wrViolation(wrViolation),
    .busy(busy), .evt(evtBus)
  );

  cryptoFlagBank flags_i (
    .clk(clk), .rstN(rstN), .evt(evtBus), .doneIrqEn(doneIrqEn),
    .errIrqEn(errIrqEn), .doneClr(doneClr), .errClr(errClr),
    .doneFlag(doneFlag), .rdErrFlag(rdErrFlag), .wrErrFlag(wrErrFlag),
    .irqOut(irqOut)
  );

  AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag); // R4
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !rdErrFlag && rdViolation) |=> !rdErrFlag); // R6

endmodule

// File: tb/cryptoStatusTop_tb_top.sv
`timescale 1ns/1ps
module cryptoStatusTop_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 0, keyLong = 0, doneIrqEn = 0, errIrqEn = 0;
  logic doneClr = 0, errClr = 0, rdViolation = 0, wrViolation = 0;
  logic [1:0] opSel = 2'b00;
  logic busy, doneFlag, rdErrFlag, wrErrFlag, irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cryptoStatusTop dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opSel(opSel),
    .keyLong(keyLong), .doneIrqEn(doneIrqEn), .errIrqEn(errIrqEn),
    .doneClr(doneClr), .errClr(errClr), .rdViolation(rdViolation),
    .wrViolation(wrViolation), .busy(busy), .doneFlag(doneFlag),
    .rdErrFlag(rdErrFlag), .wrErrFlag(wrErrFlag), .irqOut(irqOut)
  );

  function automatic int expLat(input logic [1:0] op, input logic kl);
    if (op == 2'b01) return kl ? 82 : 59;
    return kl ? 75 : 51;
  endfunction

  function automatic logic expIrq(input logic d, input logic r, input logic w,
                                  input logic de, input logic ee);
    return (d & de) | ((r | w) & ee);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleAll();
    startPulse = 0; doneClr = 0; errClr = 0; rdViolation = 0; wrViolation = 0;
  endtask

  // Launch a block and time it; optional injections at busy-cycle index k
  // kind: 0 none, 1 restart with other op, 2 write error, 3 doneClr on last cycle
  task automatic runBlock(input logic [1:0] op, input logic kl, input int kind,
                          input int k, output int cnt);
    @(negedge clk);
    idleAll();
    startPulse = 1; opSel = op; keyLong = kl;
    @(negedge clk);
    startPulse = 0;
    cnt = 0;
    while (busy && cnt < 200) begin
      cnt++;
      idleAll();
      if (kind == 1 && cnt == k) begin
        startPulse = 1; opSel = ~op; keyLong = ~kl;
      end
      if (kind == 2 && cnt == k) wrViolation = 1;
      if (kind == 3 && cnt == expLat(op, kl)) doneClr = 1;
      @(negedge clk);
    end
    idleAll();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int cnt;
    logic dExp, rExp, wExp;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 flags", {doneFlag, rdErrFlag, wrErrFlag}, 0);
    check("R1 irq", irqOut, 0);
    rstN = 1;
    @(negedge clk);

    // R2 / R3 all operation and key pairs
    for (int kl = 0; kl < 2; kl++) begin
      for (int op = 0; op < 4; op++) begin
        runBlock(2'(op), 1'(kl), 0, 0, cnt);
        check(kl ? "R3 latency" : "R2 latency", cnt, expLat(2'(op), 1'(kl)));
        check("R4 done after fall", doneFlag, 1);
        @(negedge clk); doneClr = 1; @(negedge clk); doneClr = 0;
        check("R8 doneClr", doneFlag, 0);
      end
    end

    // R5 restart mid-block ignored, inputs changed
    runBlock(2'b01, 1'b0, 1, 10, cnt);
    check("R5 restart ignored", cnt, 59);
    @(negedge clk);
    check("R5 no relaunch", busy, 0);
    doneClr = 1; @(negedge clk); doneClr = 0;

    // R6 idle violations ignored
    rdViolation = 1; wrViolation = 1; @(negedge clk); idleAll();
    check("R6 idle ignored", {rdErrFlag, wrErrFlag}, 0);

    // R7 write error near end does not abort
    runBlock(2'b00, 1'b1, 2, 74, cnt);
    check("R7 full length", cnt, 75);
    check("R7 done set", doneFlag, 1);
    check("R6 wr err set", wrErrFlag, 1);
    check("R6 rd not set", rdErrFlag, 0);

    // R10 masking with flags held
    doneIrqEn = 0; errIrqEn = 0; @(negedge clk);
    check("R10 masked irq", irqOut, 0);
    check("R10 flags kept", {doneFlag, wrErrFlag}, 3);
    errIrqEn = 1; @(negedge clk);
    check("R10 err irq", irqOut, 1);

    // R8 errClr leaves done
    errClr = 1; @(negedge clk); errClr = 0;
    check("R8 err cleared", {rdErrFlag, wrErrFlag}, 0);
    check("R8 done kept", doneFlag, 1);
    doneIrqEn = 1; errIrqEn = 0; @(negedge clk);
    check("R10 done irq", irqOut, 1);

    // R9 doneClr coincides with done event
    doneClr = 1; @(negedge clk); doneClr = 0;
    runBlock(2'b10, 1'b0, 3, 0, cnt);
    check("R9 done set wins", doneFlag, 1);

    // R9 errClr with rd event same cycle
    startPulse = 1; opSel = 2'b00; keyLong = 0; @(negedge clk); startPulse = 0;
    wrViolation = 1; @(negedge clk); wrViolation = 0;
    rdViolation = 1; errClr = 1; @(negedge clk); idleAll();
    check("R9 rd set wins", rdErrFlag, 1);
    check("R8 wr cleared", wrErrFlag, 0);
    while (busy) @(negedge clk);

    // random phase
    doneClr = 1; errClr = 1; @(negedge clk); idleAll();
    for (int i = 0; i < 25; i++) begin
      logic [1:0] op;
      logic kl;
      int k;
      op = 2'($urandom_range(0, 3));
      kl = 1'($urandom_range(0, 1));
      k  = $urandom_range(1, 90);
      dExp = doneFlag; rExp = rdErrFlag; wExp = wrErrFlag;
      runBlock(op, kl, ($urandom_range(0, 1) == 1) ? 2 : 0, k, cnt);
      check("R2 R3 random latency", cnt, expLat(op, kl));
      dExp = 1;
      check("R4 random done", doneFlag, dExp);
      doneIrqEn = 1'($urandom_range(0, 1));
      errIrqEn  = 1'($urandom_range(0, 1));
      @(negedge clk);
      check("R10 random irq", irqOut,
            expIrq(doneFlag, rdErrFlag, wrErrFlag, doneIrqEn, errIrqEn));
      if ($urandom_range(0, 1) == 1) begin
        errClr = 1; @(negedge clk); errClr = 0;
        check("R8 random errClr", {rdErrFlag, wrErrFlag}, 0);
      end
      doneClr = 1; @(negedge clk); doneClr = 0;
      check("R8 random doneClr", doneFlag, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule